// File: doc/BRIEF.md
# Fetch-Stage Next-Address Predictor with Counter Override

This block produces the next fetch address every cycle. At fetch it searches a small fully associative target cache with the whole current fetch address. A hit counts as a taken prediction, and fetch steers to the stored target. A miss sends fetch to the sequential address, which is the current address plus 4.

A cycle or more later, the decode stage presents the same branch on the decode port. It gives the branch address, the decoded target and the direction that fetch assumed for it. The block then reads a larger direct-mapped table of 2-bit saturating counters. If that counter disagrees with the fetch-time choice, the block issues a redirect. The redirect goes either to the decoded target or to the sequential path, and it outranks whatever the target cache chose in that cycle.

When a branch resolves in the execute stage, the execute port trains both structures with the actual outcome and the actual target. The instruction cache, the decoder and pipeline recovery beyond steering fetch lie outside this block.

Top module: `fpo_predictor`

## Requirements
- R1: After a synchronous active-high reset, every target-cache entry is invalid. Every counter holds 1, which is weakly not taken, so `dec_ctr_taken` reads 0 for any address.
- R2: When `fetch_pc` exactly matches the full-address tag of a valid target-cache entry, `fetch_hit` is 1. Unless a redirect is active, `next_pc` is that entry's stored target.
- R3: When there is no target-cache hit and no redirect, `fetch_hit` is 0 and `next_pc` is `fetch_pc + 4`.
- R4: The counter table has 512 entries and is indexed by address bits [10:2]. There is no tag check, so two addresses with equal bits [10:2] share one counter. A counter value of 2 or 3 means taken, and 0 or 1 means not taken.
- R5: On an execute update, the counter selected by `ex_pc` moves one step toward the outcome: up by 1 if the branch was taken, down by 1 if not. It saturates at 0 and at 3.
- R6: A redirect happens only when `dec_valid` is 1 and the counter verdict for `dec_pc` differs from `dec_fetch_taken`. The redirect address is `dec_target` if the counter says taken, and `dec_pc + 4` otherwise. `redirect` is 1 during the redirect, and a redirect outranks a target-cache hit.
- R7: On an execute update:
  - A taken branch that misses the target cache is allocated an entry holding its address and target.
  - A taken branch that hits the target cache has its stored target rewritten.
  - A not-taken branch that hits the target cache has its entry invalidated.
- R8: Allocation uses the lowest-numbered invalid entry. When all 64 entries are valid, a round-robin pointer chooses the victim. The pointer starts at entry 0 after reset and advances by one, wrapping, after each replacement of a valid entry.
- R9: When an execute update and a lookup fall in the same cycle, the fetch lookup and the decode counter read both see the contents from before the update. The update takes effect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Current fetch address |
| dec_valid | input | 1 | Decode port carries a branch this cycle |
| dec_pc | input | 32 | Address of the branch at decode |
| dec_target | input | 32 | Decoded taken target |
| dec_fetch_taken | input | 1 | Direction fetch assumed for this branch |
| ex_valid | input | 1 | Execute port carries a resolved branch |
| ex_pc | input | 32 | Address of the resolved branch |
| ex_taken | input | 1 | Actual outcome |
| ex_target | input | 32 | Actual taken target |
| next_pc | output | 32 | Next fetch address |
| fetch_hit | output | 1 | Target cache hit on `fetch_pc` |
| dec_ctr_taken | output | 1 | Counter verdict for `dec_pc` |
| redirect | output | 1 | Decode override is steering fetch |

## Verification
The bench targets the following corner cases:
- **Round-robin victim choice.** It fills all 64 entries and then forces two replacements. A design with a wrong victim pointer would evict a recently allocated branch instead of the oldest one.
- **Counter saturation.** It drives counters past both ends of their range. A counter that wrapped instead of saturating would flip its prediction.
- **Index aliasing.** It trains one address and then reads a second address with the same index bits. The second address must see the shared counter.
- **Same-cycle update and lookup.** It updates and looks up the same address in one cycle. A design that forwarded the new contents would report a hit one cycle early.
- **Override priority.** It arranges a redirect in the same cycle as a target-cache hit. A design with the multiplexer priority wrong would follow the cached target instead of the redirect.

// File: rtl/fpo_pkg.sv
package fpo_pkg;

    parameter int ADDR_W   = 32;
    parameter int TC_DEPTH = 64;
    parameter int CT_DEPTH = 512;
    parameter int WORD_OFF = 2;

    localparam int TC_IDX_W = $clog2(TC_DEPTH);
    localparam int CT_IDX_W = $clog2(CT_DEPTH);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t tag;
        addr_t target;
    } tc_entry_t;

    typedef struct packed {
        logic  valid;
        addr_t pc;
        logic  taken;
        addr_t target;
    } resolve_t;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    typedef enum logic [1:0] {
        SEL_SEQ   = 2'd0,
        SEL_CACHE = 2'd1,
        SEL_REDIR = 2'd2
    } fa_sel_t;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        r = c;
        if (taken && c != CTR_STRONG_T)
            r = ctr_t'(c + 2'd1);
        else if (!taken && c != CTR_STRONG_NT)
            r = ctr_t'(c - 2'd1);
        return r;
    endfunction

    function automatic logic ctr_is_taken(ctr_t c);
        return c[1];
    endfunction

    function automatic addr_t seq_next(addr_t a);
        return a + ADDR_W'(4);
    endfunction

endpackage

// File: rtl/fpo_target_cache.sv
module fpo_target_cache
    import fpo_pkg::*;
#(
    parameter int DEPTH = fpo_pkg::TC_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  addr_t    look_pc,
    input  resolve_t upd,
    output logic     look_hit,
    output addr_t    look_target
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tc_entry_t         ent [DEPTH];
    logic [DEPTH-1:0]  look_match;
    logic [DEPTH-1:0]  upd_match;
    logic [DEPTH-1:0]  free_vec;
    logic [IDX_W-1:0]  rr_ptr;
    logic [IDX_W-1:0]  upd_idx;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  victim;
    logic              upd_hit;
    logic              any_free;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign look_match[g] = ent[g].valid && (ent[g].tag == look_pc);
        assign upd_match[g]  = ent[g].valid && (ent[g].tag == upd.pc);
        assign free_vec[g]   = !ent[g].valid;
    end

    always_comb begin
        look_hit    = |look_match;
        look_target = '0;
        for (int i = 0; i < DEPTH; i++)
            if (look_match[i])
                look_target = ent[i].target;
    end

    always_comb begin
        upd_hit  = |upd_match;
        any_free = |free_vec;
        upd_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (upd_match[i]) upd_idx  = IDX_W'(i);
            if (free_vec[i])  free_idx = IDX_W'(i);
        end
        victim = any_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ent[i].valid <= 1'b0;
            rr_ptr <= '0;
        end else if (upd.valid) begin
            if (upd_hit) begin
                if (upd.taken)
                    ent[upd_idx].target <= upd.target;
                else
                    ent[upd_idx].valid <= 1'b0;
            end else if (upd.taken) begin
                ent[victim] <= '{valid: 1'b1, tag: upd.pc, target: upd.target};
                if (!any_free)
                    rr_ptr <= (rr_ptr == IDX_W'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpo_ctr_table.sv
module fpo_ctr_table
    import fpo_pkg::*;
#(
    parameter int DEPTH = fpo_pkg::CT_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  addr_t    rd_pc,
    input  resolve_t upd,
    output logic     rd_taken
);
    localparam int IDX_W = $clog2(DEPTH);

    ctr_t             tbl [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign rd_idx   = rd_pc[WORD_OFF +: IDX_W];
    assign wr_idx   = upd.pc[WORD_OFF +: IDX_W];
    assign rd_taken = ctr_is_taken(tbl[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                tbl[i] <= CTR_WEAK_NT;
        end else if (upd.valid) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], upd.taken);
        end
    end

endmodule

// File: rtl/fpo_fetch_mux.sv
module fpo_fetch_mux
    import fpo_pkg::*;
(
    input  addr_t   fetch_pc,
    input  logic    cache_hit,
    input  addr_t   cache_target,
    input  logic    redir_valid,
    input  addr_t   redir_pc,
    output fa_sel_t sel,
    output addr_t   next_pc
);
    always_comb begin
        if (redir_valid)    sel = SEL_REDIR;
        else if (cache_hit) sel = SEL_CACHE;
        else                sel = SEL_SEQ;
    end

    always_comb begin
        unique case (sel)
            SEL_REDIR: next_pc = redir_pc;
            SEL_CACHE: next_pc = cache_target;
            default:   next_pc = seq_next(fetch_pc);
        endcase
    end

endmodule

// File: rtl/fpo_predictor.sv
module fpo_predictor
    import fpo_pkg::*;
#(
    parameter int TC_N = fpo_pkg::TC_DEPTH,
    parameter int CT_N = fpo_pkg::CT_DEPTH
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    input  logic        dec_valid,
    input  logic [31:0] dec_pc,
    input  logic [31:0] dec_target,
    input  logic        dec_fetch_taken,
    input  logic        ex_valid,
    input  logic [31:0] ex_pc,
    input  logic        ex_taken,
    input  logic [31:0] ex_target,
    output logic [31:0] next_pc,
    output logic        fetch_hit,
    output logic        dec_ctr_taken,
    output logic        redirect
);
    resolve_t resolved;
    addr_t    cache_target;
    addr_t    redir_pc;
    fa_sel_t  sel;

    assign resolved = '{valid: ex_valid, pc: ex_pc, taken: ex_taken, target: ex_target};

    fpo_target_cache #(.DEPTH(TC_N)) u_tc (
        .clk         (clk),
        .rst         (rst),
        .look_pc     (fetch_pc),
        .upd         (resolved),
        .look_hit    (fetch_hit),
        .look_target (cache_target)
    );

    fpo_ctr_table #(.DEPTH(CT_N)) u_ct (
        .clk      (clk),
        .rst      (rst),
        .rd_pc    (dec_pc),
        .upd      (resolved),
        .rd_taken (dec_ctr_taken)
    );

    assign redirect = dec_valid && (dec_ctr_taken != dec_fetch_taken);
    assign redir_pc = dec_ctr_taken ? dec_target : seq_next(dec_pc);

    fpo_fetch_mux u_mux (
        .fetch_pc     (fetch_pc),
        .cache_hit    (fetch_hit),
        .cache_target (cache_target),
        .redir_valid  (redirect),
        .redir_pc     (redir_pc),
        .sel          (sel),
        .next_pc      (next_pc)
    );

endmodule

// File: rtl/fpo_predictor_chk.sv
module fpo_predictor_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        dec_valid,
    input logic [31:0] dec_pc,
    input logic [31:0] dec_target,
    input logic        dec_fetch_taken,
    input logic        ex_valid,
    input logic [31:0] ex_pc,
    input logic        ex_taken,
    input logic [31:0] next_pc,
    input logic        fetch_hit,
    input logic        dec_ctr_taken,
    input logic        redirect
);
    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fetch_hit);

    assert_seq_on_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid && !fetch_hit) |-> (next_pc == fetch_pc + 32'd4));

    assert_redirect_dest_R6: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (next_pc == (dec_ctr_taken ? dec_target : dec_pc + 32'd4)));

    assert_no_redirect_on_agree_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && (dec_ctr_taken == dec_fetch_taken)) |-> !redirect);

    assert_taken_allocates_R7: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_taken) |=> ((fetch_pc != $past(ex_pc)) || fetch_hit));

    assert_nottaken_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_taken) |=> ((fetch_pc != $past(ex_pc)) || !fetch_hit));

endmodule

bind fpo_predictor fpo_predictor_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .fetch_pc        (fetch_pc),
    .dec_valid       (dec_valid),
    .dec_pc          (dec_pc),
    .dec_target      (dec_target),
    .dec_fetch_taken (dec_fetch_taken),
    .ex_valid        (ex_valid),
    .ex_pc           (ex_pc),
    .ex_taken        (ex_taken),
    .next_pc         (next_pc),
    .fetch_hit       (fetch_hit),
    .dec_ctr_taken   (dec_ctr_taken),
    .redirect        (redirect)
);

// File: tb/fpo_predictor_test.sv
`timescale 1ns/1ps
module fpo_predictor_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, dec_pc, dec_target, ex_pc, ex_target;
    logic        dec_valid, dec_fetch_taken, ex_valid, ex_taken;
    logic [31:0] next_pc;
    logic        fetch_hit, dec_ctr_taken, redirect;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic        m_v   [64];
    logic [31:0] m_tag [64];
    logic [31:0] m_tgt [64];
    int          m_rr;
    logic [1:0]  m_ctr [512];

    always #5 clk = ~clk;

    fpo_predictor uut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_target(dec_target),
        .dec_fetch_taken(dec_fetch_taken),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken), .ex_target(ex_target),
        .next_pc(next_pc), .fetch_hit(fetch_hit),
        .dec_ctr_taken(dec_ctr_taken), .redirect(redirect)
    );

    function automatic int m_find(logic [31:0] a);
        for (int i = 0; i < 64; i++)
            if (m_v[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < 64; i++)
            if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        for (int i = 0; i < 512; i++) m_ctr[i] = 2'd1;
        m_rr = 0;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] fpc,
                        logic dv, logic [31:0] dpc, logic [31:0] dtg, logic dft,
                        logic ev, logic [31:0] epc, logic et, logic [31:0] etg);
        int  hi;
        int  ix;
        logic ct;
        logic red;
        logic [31:0] exp_next;
        @(negedge clk);
        fetch_pc = fpc; dec_valid = dv; dec_pc = dpc; dec_target = dtg;
        dec_fetch_taken = dft; ex_valid = ev; ex_pc = epc; ex_taken = et; ex_target = etg;
        #1;
        hi  = m_find(fpc);
        ct  = m_ctr[dpc[10:2]][1];
        red = dv && (ct != dft);
        if (red)          exp_next = ct ? dtg : dpc + 32'd4;
        else if (hi >= 0) exp_next = m_tgt[hi];
        else              exp_next = fpc + 32'd4;
        chk(tag, "next_pc", next_pc, exp_next);
        chk(tag, "fetch_hit", {31'd0, fetch_hit}, {31'd0, hi >= 0});
        chk(tag, "redirect", {31'd0, redirect}, {31'd0, red});
        if (dv) chk(tag, "dec_ctr_taken", {31'd0, dec_ctr_taken}, {31'd0, ct});
        @(posedge clk);
        if (ev) begin
            ix = m_find(epc);
            if (ix >= 0) begin
                if (et) m_tgt[ix] = etg;
                else    m_v[ix]   = 1'b0;
            end else if (et) begin
                ix = m_free();
                if (ix < 0) begin
                    ix   = m_rr;
                    m_rr = (m_rr + 1) % 64;
                end
                m_v[ix] = 1'b1; m_tag[ix] = epc; m_tgt[ix] = etg;
            end
            if (et && m_ctr[epc[10:2]] != 2'd3) m_ctr[epc[10:2]] = m_ctr[epc[10:2]] + 2'd1;
            if (!et && m_ctr[epc[10:2]] != 2'd0) m_ctr[epc[10:2]] = m_ctr[epc[10:2]] - 2'd1;
        end
    endtask

    task automatic fetch_only(string tag, logic [31:0] fpc);
        step(tag, fpc, 1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0);
    endtask

    task automatic train(string tag, logic [31:0] pc, logic t, logic [31:0] tg);
        step(tag, 32'h0000_0100, 1'b0, 32'd0, 32'd0, 1'b0, 1'b1, pc, t, tg);
    endtask

    task automatic ask(string tag, logic [31:0] pc, logic dft);
        step(tag, 32'h0000_0100, 1'b1, pc, 32'hA000_0000, dft, 1'b0, 32'd0, 1'b0, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        m_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pool [16];
        void'($urandom(32'd1234));
        fetch_pc = '0; dec_valid = 0; dec_pc = '0; dec_target = '0; dec_fetch_taken = 0;
        ex_valid = 0; ex_pc = '0; ex_taken = 0; ex_target = '0;
        rst = 1'b1;
        do_reset();

        // R1 / R3: empty cache, weak not-taken counters
        fetch_only("R1", 32'h0000_4000);
        fetch_only("R3", 32'h1234_5678);
        ask("R1", 32'h0000_0040, 1'b0);
        ask("R1", 32'h0000_07FC, 1'b0);

        // R9: update and lookup of same address in one cycle sees old state
        step("R9", 32'h0000_2000, 1'b0, 0, 0, 0, 1'b1, 32'h0000_2000, 1'b1, 32'h0000_3000);
        // R2 / R7: allocated, hits next cycle
        fetch_only("R2", 32'h0000_2000);
        // R7: taken hit rewrites target
        train("R7", 32'h0000_2000, 1'b1, 32'h0000_3300);
        fetch_only("R7", 32'h0000_2000);
        // R5: counter now 3 (1->2->3), saturate on a third taken
        train("R5", 32'h0000_2000, 1'b1, 32'h0000_3300);
        ask("R5", 32'h0000_2000, 1'b1);
        // R4: alias at +2048 shares the counter
        ask("R4", 32'h0000_2800, 1'b1);
        // R6: disagree with cache hit in the same cycle -> redirect wins
        step("R6", 32'h0000_2000, 1'b1, 32'h0000_2800, 32'h0000_5000, 1'b0,
             1'b0, 0, 0, 0);
        // R7: not-taken hit invalidates; counter 3->2 still taken
        train("R7", 32'h0000_2000, 1'b0, 32'h0);
        fetch_only("R7", 32'h0000_2000);
        ask("R5", 32'h0000_2000, 1'b0);
        // R5: drive down past zero
        for (int i = 0; i < 4; i++) train("R5", 32'h0000_2000, 1'b0, 32'h0);
        ask("R5", 32'h0000_2000, 1'b1);
        train("R5", 32'h0000_2000, 1'b1, 32'h0);
        ask("R5", 32'h0000_2000, 1'b0);

        // R8: fill, then replace round-robin
        do_reset();
        for (int i = 0; i < 64; i++)
            train("R8", 32'h0001_0000 + 32'(i * 4), 1'b1, 32'h0002_0000 + 32'(i * 16));
        fetch_only("R8", 32'h0001_0000);
        train("R8", 32'h0003_0000, 1'b1, 32'h0003_1000);
        fetch_only("R8", 32'h0001_0000);
        fetch_only("R8", 32'h0001_0004);
        fetch_only("R8", 32'h0003_0000);
        train("R8", 32'h0003_0004, 1'b1, 32'h0003_2000);
        fetch_only("R8", 32'h0001_0004);
        fetch_only("R8", 32'h0001_0008);
        // R8: a hole is refilled before the pointer is used
        train("R8", 32'h0001_0020, 1'b0, 32'h0);
        train("R8", 32'h0003_0008, 1'b1, 32'h0003_3000);
        fetch_only("R8", 32'h0001_000C);
        fetch_only("R8", 32'h0003_0008);

        // random mix against the model (R2 R3 R5 R6 R7 R9)
        do_reset();
        for (int i = 0; i < 16; i++)
            pool[i] = (i < 8) ? 32'h0000_4000 + 32'(i * 4) : 32'h0000_4800 + 32'((i - 8) * 4);
        for (int n = 0; n < 4000; n++) begin
            step("R6", pool[$urandom_range(15)],
                 1'($urandom_range(1)), pool[$urandom_range(15)],
                 32'h0008_0000 + 32'($urandom_range(255) * 4), 1'($urandom_range(1)),
                 1'($urandom_range(1)), pool[$urandom_range(15)],
                 1'($urandom_range(1)), 32'h0009_0000 + 32'($urandom_range(255) * 4));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule